// File: doc/BRIEF.md
# Video sync pin controller

This block sits between three sync pads (line, field and frame sync) and the pixel-timing logic of a graphics-to-video path. Each pad is set on its own as a receiver or as a driver. As a receiver, the pad's level passes through a two-stage synchronizer. The chosen active edge then becomes a one-cycle internal strobe: `line_start` for line timing and `field_start` for field timing. As a driver, a free-running pixel and line counter produces the pulse on the pad at the chosen polarity. The same counter also produces the internal strobes.

One polarity bit per pad does two jobs. It sets the active level when the pad is driven, and it selects the active edge when the pad is received. When the frame-sync feature is enabled, line timing, field timing or both can be taken from the frame-sync pad in place of their own pads.

A separate counter measures the input delay. It marks, with `first_pixel`, the pixel clock on which the first valid pixel arrives after the data-request signal rises.

Top module: `sync_pin_ctrl`

## Requirements
- R1: Each `*_pad_oe` output equals its direction bit: 1 means the pad is driven, 0 means it is received.
- R2: The pixel counter runs from 0 to `cfg_line_len`-1 and then wraps. While it is below `cfg_pulse_w`, `hs_pad_o` is at its active level: high when `cfg_hs_pol`=0, low when it is 1. Otherwise `hs_pad_o` is at the opposite level.
- R3: The line counter advances when the pixel counter wraps and wraps after `cfg_field_lines` lines. `vs_pad_o` is active during the whole of line 0. `fs_pad_o` is active during line 0 while the pixel counter is below `cfg_pulse_w`. Each uses its own polarity bit, encoded as in R2.
- R4: For a received pad, polarity 0 selects the rising edge and 1 selects the falling edge. The pad change reaches the strobe through two synchronizer flops, so the strobe is high for exactly one cycle: the second cycle after the clock edge that first samples the new level.
- R5: Line timing is taken from the frame-sync pad only when both `cfg_fs_en` and `cfg_h_sel_fs` are 1. Otherwise it is taken from the line-sync pad.
- R6: Field timing is taken from the frame-sync pad only when both `cfg_fs_en` and `cfg_v_sel_fs` are 1. Otherwise it is taken from the field-sync pad.
- R7: When `cfg_fs_en` is 0, edges on the frame-sync pad produce no strobe, whatever the values of the two source-select bits.
- R8: When the pad selected for a timing source is driven, its strobe comes from the counters. `line_start` is high at pixel 0 of every line. `field_start` is high at pixel 0 of line 0.
- R9: `first_pixel` is high exactly `cfg_in_delay` cycles after the cycle in which `data_req` first reads 1. With a delay of 0 it is high in that same cycle. A new rise of `data_req` restarts the count.
- R10: While reset is held, both counters are 0, the synchronizers are 0 and no delay count is running. As a result, a received pad gives no strobe and `first_pixel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hs_dir | input | 1 | Line-sync pad: 1 driven, 0 received |
| cfg_vs_dir | input | 1 | Field-sync pad: 1 driven, 0 received |
| cfg_fs_dir | input | 1 | Frame-sync pad: 1 driven, 0 received |
| cfg_hs_pol | input | 1 | Line-sync polarity / edge select |
| cfg_vs_pol | input | 1 | Field-sync polarity / edge select |
| cfg_fs_pol | input | 1 | Frame-sync polarity / edge select |
| cfg_fs_en | input | 1 | Enables the frame-sync pad as a timing source |
| cfg_h_sel_fs | input | 1 | Takes line timing from the frame-sync pad |
| cfg_v_sel_fs | input | 1 | Takes field timing from the frame-sync pad |
| cfg_line_len | input | CNT_W | Pixel clocks per line |
| cfg_field_lines | input | LINE_W | Lines per field |
| cfg_pulse_w | input | CNT_W | Width of the driven sync pulse in pixel clocks |
| cfg_in_delay | input | CNT_W | Pixel clocks from data-request rise to first pixel |
| hs_pad_i | input | 1 | Line-sync pad input |
| vs_pad_i | input | 1 | Field-sync pad input |
| fs_pad_i | input | 1 | Frame-sync pad input |
| data_req | input | 1 | Data-request signal, synchronous to clk |
| hs_pad_o | output | 1 | Line-sync pad drive value |
| hs_pad_oe | output | 1 | Line-sync pad output enable |
| vs_pad_o | output | 1 | Field-sync pad drive value |
| vs_pad_oe | output | 1 | Field-sync pad output enable |
| fs_pad_o | output | 1 | Frame-sync pad drive value |
| fs_pad_oe | output | 1 | Frame-sync pad output enable |
| line_start | output | 1 | One-cycle line timing strobe |
| field_start | output | 1 | One-cycle field timing strobe |
| first_pixel | output | 1 | Marks the first valid pixel cycle |

## Verification
In driven mode, random line lengths, pulse widths, field heights and polarities are compared cycle by cycle with a counter model. This separates wrap-point errors from pulse-width errors and from polarity inversion. In received mode, single-pad toggles of both directions are applied under every source-select and enable setting. Each toggle tells apart a wrong edge, a wrong source pad, and a frame-sync pad that leaks through while the frame-sync feature is disabled. The delay counter is tried at zero, at random values and with a restarting rise, which separates an off-by-one error from a stale countdown.

// File: rtl/sync_pin_ctrl.sv
module sync_pin_ctrl #(
  parameter int CNT_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hs_dir,
  input  logic              cfg_vs_dir,
  input  logic              cfg_fs_dir,
  input  logic              cfg_hs_pol,
  input  logic              cfg_vs_pol,
  input  logic              cfg_fs_pol,
  input  logic              cfg_fs_en,
  input  logic              cfg_h_sel_fs,
  input  logic              cfg_v_sel_fs,
  input  logic [CNT_W-1:0]  cfg_line_len,
  input  logic [LINE_W-1:0] cfg_field_lines,
  input  logic [CNT_W-1:0]  cfg_pulse_w,
  input  logic [CNT_W-1:0]  cfg_in_delay,
  input  logic              hs_pad_i,
  input  logic              vs_pad_i,
  input  logic              fs_pad_i,
  input  logic              data_req,
  output logic              hs_pad_o,
  output logic              hs_pad_oe,
  output logic              vs_pad_o,
  output logic              vs_pad_oe,
  output logic              fs_pad_o,
  output logic              fs_pad_oe,
  output logic              line_start,
  output logic              field_start,
  output logic              first_pixel
);

  logic [2:0] pin_pol, meta, stab, late, edge_hit;
  logic [CNT_W-1:0]  hcnt, dly_cnt;
  logic [LINE_W-1:0] vcnt;
  logic h_last, v_last, h_fs, v_fs, h_drv, v_drv;
  logic dreq_q, dly_busy, req_rise;

  assign pin_pol  = {cfg_fs_pol, cfg_vs_pol, cfg_hs_pol};
  assign edge_hit = (stab ^ pin_pol) & ~(late ^ pin_pol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      stab <= '0;
      late <= '0;
    end else begin
      meta <= {fs_pad_i, vs_pad_i, hs_pad_i};
      stab <= meta;
      late <= stab;
    end
  end

  assign h_last = ({1'b0, hcnt} + 1'b1) >= {1'b0, cfg_line_len};
  assign v_last = ({1'b0, vcnt} + 1'b1) >= {1'b0, cfg_field_lines};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_last) begin
      hcnt <= '0;
      vcnt <= v_last ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign hs_pad_o  = (hcnt < cfg_pulse_w) ^ cfg_hs_pol;
  assign vs_pad_o  = (vcnt == '0) ^ cfg_vs_pol;
  assign fs_pad_o  = ((vcnt == '0) && (hcnt < cfg_pulse_w)) ^ cfg_fs_pol;
  assign hs_pad_oe = cfg_hs_dir;
  assign vs_pad_oe = cfg_vs_dir;
  assign fs_pad_oe = cfg_fs_dir;

  assign h_fs  = cfg_fs_en & cfg_h_sel_fs;
  assign v_fs  = cfg_fs_en & cfg_v_sel_fs;
  assign h_drv = h_fs ? cfg_fs_dir : cfg_hs_dir;
  assign v_drv = v_fs ? cfg_fs_dir : cfg_vs_dir;

  assign line_start  = h_drv ? (hcnt == '0)
                             : (h_fs ? edge_hit[2] : edge_hit[0]);
  assign field_start = v_drv ? ((hcnt == '0) && (vcnt == '0))
                             : (v_fs ? edge_hit[2] : edge_hit[1]);

  assign req_rise = data_req & ~dreq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreq_q   <= 1'b0;
      dly_busy <= 1'b0;
      dly_cnt  <= '0;
    end else begin
      dreq_q <= data_req;
      if (req_rise) begin
        dly_cnt  <= cfg_in_delay;
        dly_busy <= cfg_in_delay != '0;
      end else if (dly_busy) begin
        dly_cnt <= dly_cnt - 1'b1;
        if (dly_cnt == CNT_W'(1)) dly_busy <= 1'b0;
      end
    end
  end

  assign first_pixel = (req_rise && cfg_in_delay == '0) ||
                       (!req_rise && dly_busy && dly_cnt == CNT_W'(1));

endmodule

// File: rtl/sync_pin_ctrl_chk.sv
module sync_pin_ctrl_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_hs_dir,
  input logic             cfg_vs_dir,
  input logic             cfg_fs_dir,
  input logic             cfg_hs_pol,
  input logic             cfg_vs_pol,
  input logic             cfg_fs_en,
  input logic             cfg_h_sel_fs,
  input logic             cfg_v_sel_fs,
  input logic [CNT_W-1:0] cfg_pulse_w,
  input logic [CNT_W-1:0] cfg_in_delay,
  input logic             data_req,
  input logic             hs_pad_o,
  input logic             vs_pad_o,
  input logic             line_start,
  input logic             field_start,
  input logic             first_pixel
);

  logic h_mst, v_mst;
  assign h_mst = (cfg_fs_en && cfg_h_sel_fs) ? cfg_fs_dir : cfg_hs_dir;
  assign v_mst = (cfg_fs_en && cfg_v_sel_fs) ? cfg_fs_dir : cfg_vs_dir;

  assert_hs_at_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_mst && cfg_hs_dir && line_start && cfg_pulse_w != '0) |-> (hs_pad_o == !cfg_hs_pol));

  assert_vs_at_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v_mst && cfg_vs_dir && field_start) |-> (vs_pad_o == !cfg_vs_pol));

  assert_line_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !h_mst) |=> !line_start);

  assert_field_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !v_mst) |=> !field_start);

  assert_field_in_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_mst && v_mst && field_start) |-> line_start);

  assert_zero_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(data_req) && cfg_in_delay == '0) |-> first_pixel);

endmodule

bind sync_pin_ctrl sync_pin_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_hs_dir(cfg_hs_dir), .cfg_vs_dir(cfg_vs_dir), .cfg_fs_dir(cfg_fs_dir),
  .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
  .cfg_fs_en(cfg_fs_en), .cfg_h_sel_fs(cfg_h_sel_fs), .cfg_v_sel_fs(cfg_v_sel_fs),
  .cfg_pulse_w(cfg_pulse_w), .cfg_in_delay(cfg_in_delay), .data_req(data_req),
  .hs_pad_o(hs_pad_o), .vs_pad_o(vs_pad_o),
  .line_start(line_start), .field_start(field_start), .first_pixel(first_pixel)
);

// File: tb/sync_pin_ctrl_test.sv
module sync_pin_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic hs_dir = 0, vs_dir = 0, fs_dir = 0, hs_pol = 0, vs_pol = 0, fs_pol = 0;
  logic fs_en = 0, h_sel = 0, v_sel = 0;
  logic [11:0] line_len = 12'd8, pulse_w = 12'd2, in_delay = 12'd0;
  logic [10:0] field_lines = 11'd3;
  logic hs_i = 0, vs_i = 0, fs_i = 0, dreq = 0;
  logic hs_o, hs_oe, vs_o, vs_oe, fs_o, fs_oe, ls, fst, fp;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_pin_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_hs_dir(hs_dir), .cfg_vs_dir(vs_dir), .cfg_fs_dir(fs_dir),
    .cfg_hs_pol(hs_pol), .cfg_vs_pol(vs_pol), .cfg_fs_pol(fs_pol),
    .cfg_fs_en(fs_en), .cfg_h_sel_fs(h_sel), .cfg_v_sel_fs(v_sel),
    .cfg_line_len(line_len), .cfg_field_lines(field_lines),
    .cfg_pulse_w(pulse_w), .cfg_in_delay(in_delay),
    .hs_pad_i(hs_i), .vs_pad_i(vs_i), .fs_pad_i(fs_i), .data_req(dreq),
    .hs_pad_o(hs_o), .hs_pad_oe(hs_oe), .vs_pad_o(vs_o), .vs_pad_oe(vs_oe),
    .fs_pad_o(fs_o), .fs_pad_oe(fs_oe),
    .line_start(ls), .field_start(fst), .first_pixel(fp)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hold_reset;
    @(negedge clk);
    rst_n = 0;
    hs_i = 0; vs_i = 0; fs_i = 0; dreq = 0;
    repeat (3) @(negedge clk);
  endtask

  function automatic bit exp_strobe(input int pin, input bit val, input bit field);
    bit pol, use_fs;
    int src;
    pol    = (pin == 0) ? hs_pol : (pin == 1) ? vs_pol : fs_pol;
    use_fs = fs_en && (field ? v_sel : h_sel);
    src    = use_fs ? 2 : (field ? 1 : 0);
    return (pin == src) && ((val ^ pol) == 1'b1);
  endfunction

  task automatic toggle(input int pin, input bit val, input string req);
    bit el, ef;
    el = exp_strobe(pin, val, 1'b0);
    ef = exp_strobe(pin, val, 1'b1);
    @(negedge clk);
    if (pin == 0) hs_i = val; else if (pin == 1) vs_i = val; else fs_i = val;
    @(negedge clk);
    #1 chk({req, " no early strobe"}, {ls, fst}, 0);
    @(negedge clk);
    #1 chk({req, " line strobe"}, ls, el);
    chk({req, " field strobe"}, fst, ef);
    @(negedge clk);
    #1 chk({req, " strobe one cycle"}, {ls, fst}, 0);
  endtask

  task automatic run_master(input int L, input int W, input int F,
                            input bit hp, input bit vp, input bit fpol);
    hold_reset();
    hs_dir = 1; vs_dir = 1; fs_dir = 1; fs_en = 0;
    hs_pol = hp; vs_pol = vp; fs_pol = fpol;
    line_len = 12'(L); pulse_w = 12'(W); field_lines = 11'(F);
    #1 chk("R2 reset level", hs_o, (W > 0) ^ hp);
    @(negedge clk);
    rst_n = 1;
    #1;
    for (int t = 0; t < 2 * L * F + 3; t++) begin
      int hp_i, vp_i;
      hp_i = t % L;
      vp_i = (t / L) % F;
      chk("R2 hs_pad_o", hs_o, (hp_i < W) ^ hp);
      chk("R3 vs_pad_o", vs_o, (vp_i == 0) ^ vp);
      chk("R3 fs_pad_o", fs_o, ((vp_i == 0) && (hp_i < W)) ^ fpol);
      chk("R8 line_start", ls, hp_i == 0);
      chk("R8 field_start", fst, (hp_i == 0) && (vp_i == 0));
      @(negedge clk);
      #1;
    end
  endtask

  task automatic slave_setup(input bit hp, input bit vp, input bit fpol,
                             input bit en, input bit hs_s, input bit vs_s);
    hold_reset();
    hs_dir = 0; vs_dir = 0; fs_dir = 0;
    hs_pol = hp; vs_pol = vp; fs_pol = fpol;
    fs_en = en; h_sel = hs_s; v_sel = vs_s;
    #1 chk("R10 no strobe in reset", {ls, fst, fp}, 0);
    @(negedge clk);
    rst_n = 1;
    hs_i = hp; vs_i = vp; fs_i = fpol;
    repeat (4) @(negedge clk);
    #1 chk("R10 idle after reset", {ls, fst}, 0);
  endtask

  task automatic delay_run(input int d);
    in_delay = 12'(d);
    @(negedge clk);
    dreq = 1;
    #1;
    for (int i = 0; i <= d + 2; i++) begin
      chk("R9 first_pixel", fp, i == d);
      @(negedge clk);
      #1;
    end
    dreq = 0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));

    hold_reset();
    hs_dir = 1; vs_dir = 0; fs_dir = 1;
    #1 chk("R1 hs_pad_oe", hs_oe, 1);
    chk("R1 vs_pad_oe", vs_oe, 0);
    chk("R1 fs_pad_oe", fs_oe, 1);
    hs_dir = 0; vs_dir = 1; fs_dir = 0;
    #1 chk("R1 oe swapped", {hs_oe, vs_oe, fs_oe}, 3'b010);

    run_master(8, 3, 3, 0, 0, 0);
    run_master(5, 1, 2, 1, 1, 1);
    for (int r = 0; r < 4; r++) begin
      int L, W;
      L = 4 + int'($urandom % 17);
      W = 1 + int'($urandom % (L - 1));
      run_master(L, W, 2 + int'($urandom % 4), $urandom % 2, $urandom % 2, $urandom % 2);
    end

    slave_setup(0, 0, 0, 0, 1, 1);
    toggle(0, 1, "R7 hs rise, fs disabled");
    toggle(2, 1, "R7 fs rise ignored");
    toggle(1, 1, "R7 vs rise, fs disabled");
    toggle(0, 0, "R4 hs fall ignored at pol 0");

    slave_setup(0, 0, 0, 1, 1, 0);
    toggle(2, 1, "R5 fs gives line");
    toggle(0, 1, "R5 hs ignored");
    toggle(1, 1, "R5 vs keeps field");

    slave_setup(0, 0, 0, 1, 0, 1);
    toggle(2, 1, "R6 fs gives field");
    toggle(1, 1, "R6 vs ignored");
    toggle(0, 1, "R6 hs keeps line");

    slave_setup(1, 1, 0, 0, 0, 0);
    toggle(0, 0, "R4 hs fall at pol 1");
    toggle(0, 1, "R4 hs rise ignored at pol 1");
    toggle(1, 0, "R4 vs fall at pol 1");

    for (int r = 0; r < 3; r++) begin
      slave_setup($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
      for (int n = 0; n < 30; n++) begin
        int p;
        bit cur;
        p = int'($urandom % 3);
        cur = (p == 0) ? hs_i : (p == 1) ? vs_i : fs_i;
        toggle(p, !cur, "R4/R5/R6/R7 random toggle");
      end
    end

    hold_reset();
    hs_dir = 0; vs_dir = 0; fs_dir = 0; fs_en = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    delay_run(0);
    delay_run(1);
    delay_run(6);
    for (int r = 0; r < 5; r++) delay_run(int'($urandom % 31));

    in_delay = 12'd5;
    @(negedge clk);
    dreq = 1;
    #1;
    for (int i = 0; i < 10; i++) begin
      chk("R9 restart", fp, i == 7);
      @(negedge clk);
      if (i == 0) dreq = 0;
      if (i == 1) dreq = 1;
      #1;
    end
    dreq = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule